// File: doc/BRIEF.md
# Temporal Dithering Colour Modulator

This block turns colour intensities into a one-bit on/off decision per colour, for a display that can only switch each LED fully on or fully off. The picture is redrawn 32 times for every displayed frame. Each redraw is a subframe. A 5-bit intensity level selects how many of those 32 subframes light the LED, and the lit subframes are spread evenly over the frame so that no single long burst is visible. Going from one level to the next adds exactly one lit subframe and keeps all the ones already lit.

Each of the red, green and blue inputs is an 8-bit component. An optional gamma stage maps the component to a 5-bit level through a square-law table. When the stage is bypassed, the level is the top five bits of the component. The caller supplies the current subframe index with every pixel. The block returns one registered on/off bit per colour, together with a registered copy of the pixel-valid strobe. Frame storage and panel timing are handled elsewhere.

Top module: `dith_modulator`

## Requirements
- R1: While reset is asserted, `pix_valid_o`, `red_on_o`, `grn_on_o` and `blu_on_o` are all 0.
- R2: `pix_valid_o` equals `pix_valid_i` from one clock earlier.
- R3: When `pix_valid_i` is 0, all three on bits are 0 on the next cycle.
- R4: For a valid pixel with level L on a channel and subframe index s, that channel's on bit in the next cycle is 1 exactly when L is not 0 and rev(s) <= L. Here rev(s) is s with its five bits in reverse order, so bit 0 of s becomes bit 4 of rev(s).
- R5: Level 0 never lights its channel, and level 31 lights it in every subframe.
- R6: Collect the on bits of one level over subframes 0 to 31 into a 32-bit word, with bit s taken from subframe s. This word has L+1 set bits for every level L from 1 to 31. Level 1 gives 0x00010001, level 7 gives 0x11111111, level 15 gives 0x55555555 and level 23 gives 0x77777777.
- R7: Every subframe lit at level L is also lit at level L+1.
- R8: With `GAMMA_EN`=1, the level of a component x is floor((31*x*x + 32512) / 65025). Component 255 maps to 31 and component 0 maps to 0.
- R9: With `GAMMA_EN`=0, the level of a component is its bits [7:3].
- R10: The three channels are independent. Each channel's on bit depends only on its own component and the shared subframe index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Pixel strobe for the inputs below |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| subframe_i | input | 5 | Index of the current redraw, 0 to 31 |
| pix_valid_o | output | 1 | Registered pixel strobe |
| red_on_o | output | 1 | Red LED on in this subframe |
| grn_on_o | output | 1 | Green LED on in this subframe |
| blu_on_o | output | 1 | Blue LED on in this subframe |

## Verification
The block has only one register stage between inputs and outputs, so any fault in the gamma table or the rank comparison appears on the on bits one cycle after the offending pixel is presented. A fault that touches only some subframe ranks stays hidden until the subframe index reaches those ranks. For that reason the bench sweeps all 32 subframes at every level and compares each collected word with the lit-count, nesting and example-word rules. A fault in the valid path shows up one cycle later as a strobe out of step with its input, or as a lit bit during an idle cycle.

// File: rtl/dith_pkg.sv
package dith_pkg;

    localparam int DITH_NCH = 3;

    // Reverse the low w bits of s: bit 0 moves to bit w-1.
    function automatic int slot_rank(input int s, input int w);
        int r;
        r = 0;
        for (int k = 0; k < w; k++) begin
            r = (r << 1) | ((s >> k) & 1);
        end
        return r;
    endfunction

    // Square-law mapping from an in_w-bit component to an lvl_w-bit level,
    // rounded to nearest.
    function automatic int gamma_level(input int v, input int in_w, input int lvl_w);
        int top_in;
        int top_lvl;
        int den;
        top_in  = (1 << in_w) - 1;
        top_lvl = (1 << lvl_w) - 1;
        den     = top_in * top_in;
        return (v * v * top_lvl + den / 2) / den;
    endfunction

    typedef struct packed {
        logic                valid;
        logic [DITH_NCH-1:0] on;
    } dith_out_t;

endpackage

// File: rtl/dith_gamma.sv
module dith_gamma
    import dith_pkg::*;
#(
    parameter int IN_W     = 8,
    parameter int LVL_W    = 5,
    parameter bit GAMMA_EN = 1'b1
) (
    input  logic [IN_W-1:0]  comp_i,
    output logic [LVL_W-1:0] lvl_o
);

    localparam int ROM_DEPTH = 1 << IN_W;

    generate
        if (GAMMA_EN) begin : g_rom
            logic [LVL_W-1:0] rom [ROM_DEPTH];
            for (genvar v = 0; v < ROM_DEPTH; v++) begin : g_entry
                assign rom[v] = LVL_W'(gamma_level(v, IN_W, LVL_W));
            end
            assign lvl_o = rom[comp_i];
        end else begin : g_bypass
            assign lvl_o = comp_i[IN_W-1 -: LVL_W];
        end
    endgenerate

endmodule

// File: rtl/dith_pattern.sv
module dith_pattern
    import dith_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] slot_i,
    output logic             on_o
);

    localparam int SLOTS = 1 << LVL_W;

    logic [SLOTS-1:0] pat;
    logic             lit;

    assign lit = (lvl_i != '0);

    // Slot i lights once the level reaches the bit-reversed rank of i.
    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            localparam logic [LVL_W-1:0] RANK = LVL_W'(slot_rank(i, LVL_W));
            assign pat[i] = lit && (RANK <= lvl_i);
        end
    endgenerate

    assign on_o = pat[slot_i];

endmodule

// File: rtl/dith_modulator.sv
module dith_modulator
    import dith_pkg::*;
#(
    parameter int IN_W     = 8,
    parameter int LVL_W    = 5,
    parameter bit GAMMA_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid_i,
    input  logic [IN_W-1:0]  red_i,
    input  logic [IN_W-1:0]  grn_i,
    input  logic [IN_W-1:0]  blu_i,
    input  logic [LVL_W-1:0] subframe_i,
    output logic             pix_valid_o,
    output logic             red_on_o,
    output logic             grn_on_o,
    output logic             blu_on_o
);

    localparam int NCH = DITH_NCH;

    logic [NCH-1:0][IN_W-1:0]  comp;
    logic [NCH-1:0][LVL_W-1:0] lvl;
    logic [NCH-1:0]            on_raw;

    dith_out_t st_d, st_q;

    assign comp = {blu_i, grn_i, red_i};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            dith_gamma #(
                .IN_W    (IN_W),
                .LVL_W   (LVL_W),
                .GAMMA_EN(GAMMA_EN)
            ) u_gamma (
                .comp_i(comp[ch]),
                .lvl_o (lvl[ch])
            );

            dith_pattern #(
                .LVL_W(LVL_W)
            ) u_pattern (
                .lvl_i (lvl[ch]),
                .slot_i(subframe_i),
                .on_o  (on_raw[ch])
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = pix_valid_i;
        st_d.on    = pix_valid_i ? on_raw : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_valid_o = st_q.valid;
    assign red_on_o    = st_q.on[0];
    assign grn_on_o    = st_q.on[1];
    assign blu_on_o    = st_q.on[2];

endmodule

// File: rtl/dith_modulator_chk.sv
module dith_modulator_chk #(
    parameter int LVL_W = 5,
    parameter int NCH   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pix_valid_i,
    input logic [LVL_W-1:0]          subframe_i,
    input logic [NCH-1:0][LVL_W-1:0] lvl_i,
    input logic                      pix_valid_o,
    input logic [NCH-1:0]            on_i
);

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o);

    assert_idle_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> (on_i == '0));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            assert_full_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (pix_valid_i && lvl_i[c] == {LVL_W{1'b1}}) |=> on_i[c]);

            assert_zero_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl_i[c] == '0) |=> !on_i[c]);

            assert_first_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (pix_valid_i && lvl_i[c] != '0 && subframe_i == '0) |=> on_i[c]);
        end
    endgenerate

endmodule

bind dith_modulator dith_modulator_chk #(
    .LVL_W(LVL_W),
    .NCH  (NCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid_i(pix_valid_i),
    .subframe_i (subframe_i),
    .lvl_i      (lvl),
    .pix_valid_o(pix_valid_o),
    .on_i       ({blu_on_o, grn_on_o, red_on_o})
);

// File: tb/dith_modulator_tb.sv
module dith_modulator_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] r = '0, g = '0, b = '0;
    logic [4:0] sf = '0;

    logic gv, gr, gg, gb;   // gamma instance
    logic bv, br, bg, bb;   // bypass instance

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dith_modulator #(.GAMMA_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(vld),
        .red_i(r), .grn_i(g), .blu_i(b), .subframe_i(sf),
        .pix_valid_o(gv), .red_on_o(gr), .grn_on_o(gg), .blu_on_o(gb)
    );

    dith_modulator #(.GAMMA_EN(1'b0)) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(vld),
        .red_i(r), .grn_i(g), .blu_i(b), .subframe_i(sf),
        .pix_valid_o(bv), .red_on_o(br), .grn_on_o(bg), .blu_on_o(bb)
    );

    function automatic int lvl_gamma(input int x);
        return (31 * x * x + 32512) / 65025;
    endfunction

    function automatic int rev5(input int s);
        return ((s & 1) << 4) | ((s & 2) << 2) | (s & 4) | ((s & 8) >> 2) | ((s & 16) >> 4);
    endfunction

    function automatic bit lit(input int level, input int s);
        return (level != 0) && (rev5(s) <= level);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge register, sample at the next falling edge.
    task automatic step(input bit v, input int rv, input int gv_, input int bv_, input int s);
        @(negedge clk);
        vld = v; r = 8'(rv); g = 8'(gv_); b = 8'(bv_); sf = 5'(s);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_pixel(input bit v, input int rv, input int gv_, input int bv_, input int s);
        step(v, rv, gv_, bv_, s);
        check("R2 valid gamma", {31'd0, gv}, {31'd0, v});
        check("R2 valid bypass", {31'd0, bv}, {31'd0, v});
        check("R4/R8/R10 red gamma", {31'd0, gr}, {31'd0, v && lit(lvl_gamma(rv), s)});
        check("R4/R8/R10 grn gamma", {31'd0, gg}, {31'd0, v && lit(lvl_gamma(gv_), s)});
        check("R4/R8/R10 blu gamma", {31'd0, gb}, {31'd0, v && lit(lvl_gamma(bv_), s)});
        check("R4/R9/R10 red bypass", {31'd0, br}, {31'd0, v && lit(rv >> 3, s)});
        check("R4/R9/R10 grn bypass", {31'd0, bg}, {31'd0, v && lit(gv_ >> 3, s)});
        check("R4/R9/R10 blu bypass", {31'd0, bb}, {31'd0, v && lit(bv_ >> 3, s)});
    endtask

    // Collect one level's 32-bit word from the bypass instance, all channels equal.
    task automatic sweep(input int level, output logic [31:0] word);
        logic [31:0] wg, wb;
        word = '0; wg = '0; wb = '0;
        for (int s = 0; s < 32; s++) begin
            step(1'b1, level << 3, level << 3, level << 3, s);
            word[s] = br; wg[s] = bg; wb[s] = bb;
        end
        check("R10 grn word matches red", wg, word);
        check("R10 blu word matches red", wb, word);
    endtask

    initial begin
        logic [31:0] prev_w, w;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset gamma", {28'd0, gv, gr, gg, gb}, 32'd0);
        check("R1 reset bypass", {28'd0, bv, br, bg, bb}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5/R6/R7: full sweep of every level
        prev_w = '0;
        for (int lv = 0; lv < 32; lv++) begin
            sweep(lv, w);
            check("R6 lit count", 32'($countones(w)), (lv == 0) ? 32'd0 : 32'(lv + 1));
            check("R7 nested words", w & prev_w, prev_w);
            if (lv == 0)  check("R5 level 0 dark", w, 32'h0000_0000);
            if (lv == 1)  check("R6 level 1 word", w, 32'h0001_0001);
            if (lv == 7)  check("R6 level 7 word", w, 32'h1111_1111);
            if (lv == 15) check("R6 level 15 word", w, 32'h5555_5555);
            if (lv == 23) check("R6 level 23 word", w, 32'h7777_7777);
            if (lv == 31) check("R5 level 31 lit", w, 32'hFFFF_FFFF);
            prev_w = w;
        end

        // R8: gamma corners
        for (int s = 0; s < 32; s++) check_pixel(1'b1, 255, 0, 128, s);
        check_pixel(1'b1, 16, 17, 46, 0);
        check_pixel(1'b1, 47, 200, 254, 31);

        // R3: idle cycles with bright components stay dark
        for (int s = 0; s < 4; s++) begin
            step(1'b0, 255, 255, 255, s);
            check("R3 idle gamma dark", {29'd0, gr, gg, gb}, 32'd0);
            check("R3 idle bypass dark", {29'd0, br, bg, bb}, 32'd0);
            check("R2 idle valid low", {30'd0, gv, bv}, 32'd0);
        end

        // Random mix: R2 R4 R8 R9 R10
        for (int n = 0; n < 3000; n++) begin
            check_pixel(($urandom % 8) != 0, $urandom % 256, $urandom % 256,
                        $urandom % 256, $urandom % 32);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule